// File: doc/BRIEF.md
# Big-Number Accelerator Operand and Launch Registers

This block is the host-side register bank for a multi-word arithmetic accelerator. Software programs four operand word addresses, two operand lengths, a shift amount and an operation code over a simple 32-bit register bus. It then sets a run bit to start a job in the attached datapath. The datapath sees the committed operand set on dedicated output ports. It reports the end of a job with a single-cycle done pulse that carries the compare flags and two result word addresses. The block latches these values into read-only result registers.

While a job is running, software may prepare the next job. Writes to the address and length registers go to a shadow copy, and that copy becomes visible once the job ends. Writes to the shift amount and to the operation code are dropped while a job runs. An optional stall bit keeps the previous results readable: a job that finishes while stall is set does not update the result registers and does not clear run until software clears stall. The interrupt output is the inverse of the run bit. After reset the run bit reads as 1 until the sequencer side signals that it is ready.

Top module: `bnacc_launch_regs`

## Requirements
- R1: After reset, all operand address, length, shift, operation and result registers read 0, the run bit (bit 15 of the function register, word index 0) reads 1 and `irq_o` is 0. A `seq_ready_i` pulse clears run, and `irq_o` then reads 1.
- R2: With run low, a write to an operand address register (word index 1 to 4 for A to D, 11 bits) or a length register (word index 5 for A and 6 for B, 9 bits) takes effect at the write edge. Only the low field bits are kept.
- R3: With run high, a write to an address or length register leaves the readback and the datapath port unchanged. The written value becomes visible in the same cycle that run clears. A register that was not written keeps its value.
- R4: With run low, a write to word index 0 with bit 15 set sets run and captures bits [11:0] as the operation code. `start_o` is high for exactly the one cycle after the write edge.
- R5: With run high, writes to the shift register (word index 7) and to operation bits [11:0] are ignored. A write that sets bit 15 does not produce another `start_o` pulse.
- R6: A `done_i` pulse while a job runs with stall clear loads compare (word index 8, 3 bits), MSW (word index 9) and DIVMSW (word index 10) and clears run at the same edge. `irq_o` is always the inverse of run.
- R7: Bit 24 of word index 0 is the stall bit. If a job ends while stall is set, the result registers keep their old values and run stays high. After software writes stall to 0, the held results are committed and run clears one cycle after that write edge.
- R8: `done_i` is ignored while run is low and before `seq_ready_i` has been seen: the result registers do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| seq_ready_i | input | 1 | Sequencer ready pulse, clears the reset-time run bit |
| start_o | output | 1 | One-cycle job start pulse |
| op_o | output | 12 | Operation code of the current job |
| shift_o | output | 5 | Shift amount |
| ptr_a_o | output | 11 | Operand A word address |
| ptr_b_o | output | 11 | Operand B word address |
| ptr_c_o | output | 11 | Operand C word address |
| ptr_d_o | output | 11 | Operand D word address |
| len_a_o | output | 9 | Operand A length in words |
| len_b_o | output | 9 | Operand B length in words |
| done_i | input | 1 | Job finished pulse from the datapath |
| cmp_i | input | 3 | Compare flags of the finished job |
| msw_i | input | 11 | Most-significant-word address of the result |
| divmsw_i | input | 11 | Most-significant-word address of the remainder |
| irq_o | output | 1 | Completion interrupt, inverse of run |

## Verification
The launch path is tried in three ways: a plain launch with stall clear, a launch with stall set, and launch attempts while run is already high. Comparing the cycle in which run falls and results appear separates a direct commit from a held commit that waits one cycle after the release. Register writes are issued both with run low and with run high, and readback is checked before and after completion. This tells immediate update, shadowed update and dropped writes apart, and confirms that an unwritten shadowed register keeps its value. Done pulses sent while idle and during the reset-time run phase show that stray completions leave the results untouched.

// File: rtl/bnacc_pkg.sv
package bnacc_pkg;
  localparam int PTR_W    = 11;
  localparam int LEN_W    = 9;
  localparam int SHIFT_W  = 5;
  localparam int CMP_W    = 3;
  localparam int OP_W     = 12;
  localparam int RUN_BIT  = 15;
  localparam int STALL_BIT = 24;
  localparam int N_PTR    = 4;
  localparam int N_LEN    = 2;

  typedef enum logic [3:0] {
    RA_FUNC  = 4'd0,
    RA_PTR_A = 4'd1,
    RA_PTR_B = 4'd2,
    RA_PTR_C = 4'd3,
    RA_PTR_D = 4'd4,
    RA_LEN_A = 4'd5,
    RA_LEN_B = 4'd6,
    RA_SHIFT = 4'd7,
    RA_CMP   = 4'd8,
    RA_MSW   = 4'd9,
    RA_DMSW  = 4'd10
  } reg_addr_e;
endpackage

// File: rtl/bnacc_shadow_reg.sv
module bnacc_shadow_reg #(
  parameter int W = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  input  logic         busy_i,
  input  logic         commit_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q, sh_q;
  logic         full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q    <= '0;
      sh_q   <= '0;
      full_q <= 1'b0;
    end else if (we_i) begin
      if (busy_i && !commit_i) begin
        sh_q   <= d_i;
        full_q <= 1'b1;
      end else begin
        q_q    <= d_i;
        full_q <= 1'b0;
      end
    end else if (commit_i && full_q) begin
      q_q    <= sh_q;
      full_q <= 1'b0;
    end
  end

  assign q_o = q_q;

  // R3: the visible copy does not move while a job runs
  p_shadow_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !commit_i) |=> $stable(q_q));
endmodule

// File: rtl/bnacc_run_ctrl.sv
module bnacc_run_ctrl #(
  parameter int CMP_W = 3,
  parameter int PTR_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             seq_ready_i,
  input  logic             fn_we_i,
  input  logic             run_wr_i,
  input  logic             stall_wr_i,
  input  logic             done_i,
  input  logic [CMP_W-1:0] cmp_i,
  input  logic [PTR_W-1:0] msw_i,
  input  logic [PTR_W-1:0] dmsw_i,
  output logic             run_o,
  output logic             stall_o,
  output logic             start_o,
  output logic             commit_o,
  output logic [CMP_W-1:0] cmp_o,
  output logic [PTR_W-1:0] msw_o,
  output logic [PTR_W-1:0] dmsw_o
);
  logic             boot_q, run_q, stall_q, pend_q, start_q;
  logic [CMP_W-1:0] cmp_q, cmp_h;
  logic [PTR_W-1:0] msw_q, msw_h, dmsw_q, dmsw_h;
  logic             launch, done_acc, fin_direct, fin_held, boot_end;

  assign launch     = fn_we_i && run_wr_i && !run_q;
  assign done_acc   = done_i && run_q && !boot_q && !pend_q;
  assign fin_direct = done_acc && !stall_q;
  assign fin_held   = pend_q && !stall_q;
  assign boot_end   = boot_q && seq_ready_i;
  assign commit_o   = fin_direct || fin_held || boot_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      boot_q  <= 1'b1;
      run_q   <= 1'b1;
      stall_q <= 1'b0;
      pend_q  <= 1'b0;
      start_q <= 1'b0;
      cmp_q   <= '0;
      cmp_h   <= '0;
      msw_q   <= '0;
      msw_h   <= '0;
      dmsw_q  <= '0;
      dmsw_h  <= '0;
    end else begin
      start_q <= launch;
      if (fn_we_i) stall_q <= stall_wr_i;
      if (boot_end) begin
        boot_q <= 1'b0;
        run_q  <= 1'b0;
      end
      if (launch) run_q <= 1'b1;
      if (fin_direct) begin
        cmp_q  <= cmp_i;
        msw_q  <= msw_i;
        dmsw_q <= dmsw_i;
        run_q  <= 1'b0;
      end
      if (done_acc && stall_q) begin
        cmp_h  <= cmp_i;
        msw_h  <= msw_i;
        dmsw_h <= dmsw_i;
        pend_q <= 1'b1;
      end
      if (fin_held) begin
        cmp_q  <= cmp_h;
        msw_q  <= msw_h;
        dmsw_q <= dmsw_h;
        run_q  <= 1'b0;
        pend_q <= 1'b0;
      end
    end
  end

  assign run_o   = run_q;
  assign stall_o = stall_q;
  assign start_o = start_q;
  assign cmp_o   = cmp_q;
  assign msw_o   = msw_q;
  assign dmsw_o  = dmsw_q;

  p_launch_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fn_we_i && run_wr_i && !run_q) |=> (run_q && start_q));

  p_done_commit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && run_q && !boot_q && !pend_q && !stall_q) |=> (!run_q && msw_q == $past(msw_i)));

  p_stall_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && run_q && !boot_q && !pend_q && stall_q) |=> (run_q && $stable(msw_q) && $stable(cmp_q)));

  p_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !stall_q) |=> !run_q);

  p_idle_results_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q || boot_q) |=> ($stable(msw_q) && $stable(dmsw_q) && $stable(cmp_q)));
endmodule

// File: rtl/bnacc_launch_regs.sv
module bnacc_launch_regs
  import bnacc_pkg::*;
#(
  parameter int P_W  = PTR_W,
  parameter int L_W  = LEN_W,
  parameter int S_W  = SHIFT_W,
  parameter int C_W  = CMP_W,
  parameter int O_W  = OP_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic [3:0]     addr_i,
  input  logic [31:0]    wdata_i,
  output logic [31:0]    rdata_o,
  input  logic           seq_ready_i,
  output logic           start_o,
  output logic [O_W-1:0] op_o,
  output logic [S_W-1:0] shift_o,
  output logic [P_W-1:0] ptr_a_o,
  output logic [P_W-1:0] ptr_b_o,
  output logic [P_W-1:0] ptr_c_o,
  output logic [P_W-1:0] ptr_d_o,
  output logic [L_W-1:0] len_a_o,
  output logic [L_W-1:0] len_b_o,
  input  logic           done_i,
  input  logic [C_W-1:0] cmp_i,
  input  logic [P_W-1:0] msw_i,
  input  logic [P_W-1:0] divmsw_i,
  output logic           irq_o
);
  logic           run, stall, commit, fn_we;
  logic [P_W-1:0] ptr_q [N_PTR];
  logic [L_W-1:0] len_q [N_LEN];
  logic [C_W-1:0] cmp_q;
  logic [P_W-1:0] msw_q, dmsw_q;
  logic [O_W-1:0] op_q;
  logic [S_W-1:0] shift_q;

  assign fn_we = wr_en_i && (addr_i == RA_FUNC);

  for (genvar i = 0; i < N_PTR; i++) begin : g_ptr
    bnacc_shadow_reg #(.W(P_W)) u_ptr (
      .clk_i, .rst_ni,
      .we_i    (wr_en_i && (addr_i == 4'(int'(RA_PTR_A) + i))),
      .d_i     (wdata_i[P_W-1:0]),
      .busy_i  (run),
      .commit_i(commit),
      .q_o     (ptr_q[i])
    );
  end

  for (genvar i = 0; i < N_LEN; i++) begin : g_len
    bnacc_shadow_reg #(.W(L_W)) u_len (
      .clk_i, .rst_ni,
      .we_i    (wr_en_i && (addr_i == 4'(int'(RA_LEN_A) + i))),
      .d_i     (wdata_i[L_W-1:0]),
      .busy_i  (run),
      .commit_i(commit),
      .q_o     (len_q[i])
    );
  end

  bnacc_run_ctrl #(.CMP_W(C_W), .PTR_W(P_W)) u_run (
    .clk_i, .rst_ni,
    .seq_ready_i,
    .fn_we_i   (fn_we),
    .run_wr_i  (wdata_i[RUN_BIT]),
    .stall_wr_i(wdata_i[STALL_BIT]),
    .done_i,
    .cmp_i,
    .msw_i,
    .dmsw_i    (divmsw_i),
    .run_o     (run),
    .stall_o   (stall),
    .start_o,
    .commit_o  (commit),
    .cmp_o     (cmp_q),
    .msw_o     (msw_q),
    .dmsw_o    (dmsw_q)
  );

  // op code and shift are frozen while run is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= '0;
      shift_q <= '0;
    end else if (!run) begin
      if (fn_we) op_q <= wdata_i[O_W-1:0];
      if (wr_en_i && addr_i == RA_SHIFT) shift_q <= wdata_i[S_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      RA_FUNC: begin
        rdata_o[O_W-1:0]  = op_q;
        rdata_o[RUN_BIT]  = run;
        rdata_o[STALL_BIT] = stall;
      end
      RA_PTR_A: rdata_o[P_W-1:0] = ptr_q[0];
      RA_PTR_B: rdata_o[P_W-1:0] = ptr_q[1];
      RA_PTR_C: rdata_o[P_W-1:0] = ptr_q[2];
      RA_PTR_D: rdata_o[P_W-1:0] = ptr_q[3];
      RA_LEN_A: rdata_o[L_W-1:0] = len_q[0];
      RA_LEN_B: rdata_o[L_W-1:0] = len_q[1];
      RA_SHIFT: rdata_o[S_W-1:0] = shift_q;
      RA_CMP:   rdata_o[C_W-1:0] = cmp_q;
      RA_MSW:   rdata_o[P_W-1:0] = msw_q;
      RA_DMSW:  rdata_o[P_W-1:0] = dmsw_q;
      default:  rdata_o = '0;
    endcase
  end

  assign op_o    = op_q;
  assign shift_o = shift_q;
  assign ptr_a_o = ptr_q[0];
  assign ptr_b_o = ptr_q[1];
  assign ptr_c_o = ptr_q[2];
  assign ptr_d_o = ptr_q[3];
  assign len_a_o = len_q[0];
  assign len_b_o = len_q[1];
  assign irq_o   = !run;

  p_op_frozen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |=> ($stable(op_q) && $stable(shift_q)));

  p_single_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
endmodule

// File: tb/tb_bnacc_launch_regs.sv
`timescale 1ns/1ps
module tb_bnacc_launch_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        seq_ready = 1'b0;
  logic        start;
  logic [11:0] op;
  logic [4:0]  shift;
  logic [10:0] pa, pb, pc, pd;
  logic [8:0]  la, lb;
  logic        done = 1'b0;
  logic [2:0]  cmp = '0;
  logic [10:0] msw = '0, dmsw = '0;
  logic        irq;
  int          total = 0, bad = 0;

  always #2.5 clk = ~clk;

  bnacc_launch_regs dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .seq_ready_i(seq_ready), .start_o(start), .op_o(op), .shift_o(shift),
    .ptr_a_o(pa), .ptr_b_o(pb), .ptr_c_o(pc), .ptr_d_o(pd), .len_a_o(la), .len_b_o(lb),
    .done_i(done), .cmp_i(cmp), .msw_i(msw), .divmsw_i(dmsw), .irq_o(irq)
  );

  localparam logic [31:0] RUN = 32'h0000_8000;
  localparam logic [31:0] STL = 32'h0100_0000;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic pulse_done(logic [2:0] c, logic [10:0] m, logic [10:0] dm);
    @(negedge clk);
    done = 1'b1; cmp = c; msw = m; dmsw = dm;
    @(negedge clk);
    done = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(4'd0, v); chk("R1 run after reset", v[15], 1);
    chk("R1 irq after reset", irq, 0);
    rd(4'd1, v); chk("R1 ptr A reset", v, 0);
    rd(4'd9, v); chk("R1 msw reset", v, 0);
    pulse_done(3'd1, 11'h3, 11'h4);
    rd(4'd9, v); chk("R8 done during boot ignored", v, 0);
    rd(4'd0, v); chk("R8 run still set in boot", v[15], 1);
    @(negedge clk); seq_ready = 1'b1;
    @(negedge clk); seq_ready = 1'b0;
    rd(4'd0, v); chk("R1 run cleared by ready", v[15], 0);
    chk("R1 irq after ready", irq, 1);
  endtask

  task automatic t_idle_write();
    logic [31:0] v;
    wr(4'd1, 32'hFFFF_FFFF);
    rd(4'd1, v); chk("R2 ptr A masked", v, 32'h7FF);
    chk("R2 ptr A port", pa, 11'h7FF);
    wr(4'd5, 32'h0000_03FF);
    rd(4'd5, v); chk("R2 len A masked", v, 32'h1FF);
    wr(4'd4, 32'h0000_0321);
    chk("R2 ptr D port", pd, 11'h321);
  endtask

  task automatic t_launch_and_busy();
    logic [31:0] v;
    wr(4'd7, 32'd3);
    wr(4'd0, RUN | 32'h010);
    chk("R4 start pulse", start, 1);
    chk("R4 op captured", op, 12'h010);
    chk("R6 irq low while running", irq, 0);
    @(negedge clk);
    chk("R4 start single cycle", start, 0);
    wr(4'd1, 32'h123);
    rd(4'd1, v); chk("R3 busy write shadowed", v, 32'h7FF);
    chk("R3 port unchanged", pa, 11'h7FF);
    wr(4'd7, 32'd7);
    chk("R5 shift ignored", shift, 5'd3);
    wr(4'd0, RUN | 32'h020);
    chk("R5 no relaunch", start, 0);
    chk("R5 op ignored", op, 12'h010);
    pulse_done(3'd2, 11'h055, 11'h066);
    rd(4'd0, v); chk("R6 run cleared", v[15], 0);
    chk("R6 irq high", irq, 1);
    rd(4'd9, v); chk("R6 msw", v, 32'h055);
    rd(4'd10, v); chk("R6 divmsw", v, 32'h066);
    rd(4'd8, v); chk("R6 cmp", v, 32'h2);
    rd(4'd1, v); chk("R3 shadow committed", v, 32'h123);
    rd(4'd2, v); chk("R3 unwritten kept", v, 0);
  endtask

  task automatic t_idle_done();
    logic [31:0] v;
    pulse_done(3'd4, 11'h111, 11'h222);
    rd(4'd9, v); chk("R8 idle done ignored", v, 32'h055);
    rd(4'd8, v); chk("R8 idle cmp kept", v, 32'h2);
  endtask

  task automatic t_stall();
    logic [31:0] v;
    wr(4'd0, STL | RUN | 32'h001);
    chk("R4 start with stall", start, 1);
    pulse_done(3'd1, 11'h0AA, 11'h0BB);
    rd(4'd0, v); chk("R7 run held", v[15], 1);
    rd(4'd9, v); chk("R7 msw held old", v, 32'h055);
    @(negedge clk);
    rd(4'd0, v); chk("R7 still held", v[15], 1);
    wr(4'd0, 32'h0);
    rd(4'd0, v); chk("R7 not yet released", v[15], 1);
    @(negedge clk);
    rd(4'd0, v); chk("R7 released", v[15], 0);
    rd(4'd9, v); chk("R7 msw committed", v, 32'h0AA);
    rd(4'd10, v); chk("R7 divmsw committed", v, 32'h0BB);
    rd(4'd8, v); chk("R7 cmp committed", v, 32'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_write();
    t_launch_and_busy();
    t_idle_done();
    t_stall();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule